// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a slave on a two-wire SMBus-compatible bus. It lets a host read and write a small bank of 8-bit configuration registers that the rest of the chip uses directly. SCL and SDA are taken in as plain inputs and sampled on a system clock that runs at least eight times faster than SCL. The slave never drives SDA high: it only asserts an open-drain pull-down enable.

The command byte picks one of two access styles. With bit 7 set, bits 6:0 give a single register offset for a byte write or byte read. With bit 7 clear, the access is a block transfer that always begins at register 0. A block write sends a byte count and then the data. A block read first returns the count held in register 12 and then that many registers in ascending order. Register 7 holds identification data: it shows a value fed in from outside and cannot be written. The whole bank is presented on a flat output bus.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges only address bytes 0xD2 (write) and 0xD3 (read). Any other address is not acknowledged, and the slave stays off the bus until the next START.
- R2: A byte write (address 0xD2, command with bit 7 = 1 and the offset in bits 6:0, one data byte) stores the data byte in that register. Every byte is acknowledged.
- R3: A byte read (address 0xD2, command 0x80|offset, repeated START, address 0xD3) returns that register MSB first. After the master NACKs, SDA is released and further SCL pulses read as 0xFF until the next START.
- R4: A block write (command 0x00, a count byte, then data) stores the data bytes in registers 0, 1, 2, ... in order. Every byte is acknowledged.
- R5: A block read (command 0x00, repeated START, 0xD3) returns the value of register 12 first, then registers 0 upward, as many as that value. Once those bytes are sent, the slave releases SDA, so any further byte reads as 0xFF.
- R6: Reset loads these values into registers 0 to 14: A1, 85, FF, FF, ED, 00, 00, (id), 80, 25, 03, 07, 0F, FC, A4 (hex). Register 12, the block-read count, therefore starts at 15.
- R7: Register 7 always shows the id_byte input, both on regs_o and when read. A write to it is acknowledged and discarded.
- R8: A write to an offset of 15 or above is acknowledged and changes no register. A read of such an offset returns 0x00.
- R9: A STOP or a new START in the middle of a byte abandons the transfer: the partial byte writes nothing, and a new transaction after the START works normally.
- R10: sda_oe changes only while SCL is low, and it is 0 whenever the slave is idle or after a STOP.
- R11: regs_o[8*i+7:8*i] holds register i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| id_byte | input | 8 | Read-only identification value shown as register 7 |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits 8i+7:8i |

## Verification
Both bus lines pass through a two-flop synchronizer and then an edge register. The slave therefore changes sda_oe three system cycles after SCL falls: for an acknowledge, for a transmitted bit and for a release. It samples SDA three cycles after SCL rises. The bench master holds each SCL phase for ten system cycles and samples SDA in the middle of the high phase, well after that three-cycle lag. A register written on a bus write changes about three cycles after the SCL fall that ends its eighth bit, so the bench reads regs_o only after the STOP has completed, many cycles later.

// File: rtl/smb_cfg_slave.sv
`timescale 1ns/1ps
module smb_cfg_slave #(
  parameter int NUM_REGS = 15,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int ID_IDX = 7,
  parameter int CNT_IDX = 12,
  parameter logic [NUM_REGS*8-1:0] RST_VALS = 120'hA4_FC_0F_07_03_25_80_00_00_00_ED_FF_FF_85_A1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic [7:0]            id_byte,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IW = $clog2(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_CNT, P_DATA} ph_t;

  logic [2:0] scl_sy, sda_sy;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  st_t        state;
  ph_t        phase;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txb, left;
  logic [6:0] ptr;
  logic       rnw, blk, cnt_pend;
  logic [7:0] regs [NUM_REGS];
  logic [7:0] rd_byte, nxt;
  logic       load_now, rd_done, wr_ok;

  assign scl_s = scl_sy[1];
  assign scl_p = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_p = sda_sy[2];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  assign rd_byte = (ptr >= 7'(NUM_REGS)) ? 8'h00 :
                   (ptr == 7'(ID_IDX))   ? id_byte : regs[ptr[IW-1:0]];
  assign nxt      = cnt_pend ? regs[CNT_IDX] : rd_byte;
  assign wr_ok    = (ptr < 7'(NUM_REGS)) && (ptr != 7'(ID_IDX));
  assign load_now = scl_fall && ((state == S_RACK && rnw) || state == S_TACK);
  assign rd_done  = blk && !cnt_pend && (left == 8'd0);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    if (i == ID_IDX) begin : g_id
      assign regs_o[i*8 +: 8] = id_byte;
    end else begin : g_rw
      assign regs_o[i*8 +: 8] = regs[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; phase <= P_ADDR; bitcnt <= '0;
      shreg <= '0; txb <= '0; left <= '0; ptr <= '0;
      rnw <= 1'b0; blk <= 1'b0; cnt_pend <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= RST_VALS[i*8 +: 8];
    end else if (bus_start) begin
      state <= S_RX; phase <= P_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (bus_stop) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX:
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            state  <= S_RACK;
            sda_oe <= 1'b1;
            case (phase)
              P_ADDR:
                if (shreg[7:1] != DEV_ADDR) begin
                  state <= S_IDLE; sda_oe <= 1'b0;
                end else begin
                  rnw <= shreg[0];
                  phase <= P_CMD;
                  if (shreg[0] && blk) begin
                    ptr <= '0; cnt_pend <= 1'b1; left <= regs[CNT_IDX];
                  end
                end
              P_CMD: begin
                blk   <= ~shreg[7];
                ptr   <= shreg[7] ? shreg[6:0] : 7'd0;
                phase <= shreg[7] ? P_DATA : P_CNT;
              end
              P_CNT: phase <= P_DATA;
              default: begin
                if (wr_ok) regs[ptr[IW-1:0]] <= shreg;
                ptr <= ptr + 7'd1;
              end
            endcase
          end
        S_RACK:
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= S_RX;
          end
        S_TX:
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0; state <= S_TACK;
            end else begin
              sda_oe <= ~txb[7];
              txb    <= {txb[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
        S_TACK:
          if (scl_rise && sda_s) state <= S_IDLE;
        default: ;
      endcase
      if (load_now) begin
        if (rd_done) begin
          state <= S_IDLE; sda_oe <= 1'b0;
        end else begin
          state  <= S_TX;
          bitcnt <= 4'd1;
          sda_oe <= ~nxt[7];
          txb    <= {nxt[6:0], 1'b0};
          if (cnt_pend) cnt_pend <= 1'b0;
          else begin
            ptr <= ptr + 7'd1;
            if (blk) left <= left - 8'd1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
`timescale 1ns/1ps
module smb_cfg_slave_chk #(
  parameter int NW = 120
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_s,
  input logic          sda_oe,
  input logic [2:0]    state,
  input logic [7:0]    id_byte,
  input logic [NW-1:0] regs_o
);
  // state 3'd0 is the idle encoding
  assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> !sda_oe);

  assert_stop_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> (!sda_oe && state == 3'd0));

  assert_regs_move_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(regs_o) && $stable(id_byte)) |-> !scl_s);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NW(NUM_REGS*8)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .sda_oe(sda_oe),
  .state(state), .id_byte(id_byte), .regs_o(regs_o)
);

// File: tb/smb_cfg_slave_bench.sv
`timescale 1ns/1ps
module smb_cfg_slave_bench;
  localparam int N = 15;
  localparam int Q = 10;
  localparam logic [N*8-1:0] DEF = 120'hA4_FC_0F_07_03_25_80_00_00_00_ED_FF_FF_85_A1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] id_val = 8'h48;
  logic [N*8-1:0] regs_o;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  smb_cfg_slave u_smb_cfg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .id_byte(id_val), .regs_o(regs_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold(); m_sda = 1'b0; hold(); m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold(); m_scl = 1'b1; hold(); m_sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; hold(); m_scl = 1'b1; hold(); m_scl = 1'b0; hold();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_sda = 1'b1; hold(); m_scl = 1'b1; hold();
    ack = ~sda_bus;
    m_scl = 1'b0; hold();
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(); m_scl = 1'b1; hold(); b[i] = sda_bus; m_scl = 1'b0;
    end
    hold(); m_sda = nack; hold(); m_scl = 1'b1; hold(); m_scl = 1'b0; hold(); m_sda = 1'b1;
  endtask

  task automatic wr_reg(input logic [6:0] off, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start(); send_byte(8'hD2, a0); send_byte({1'b1, off}, a1); send_byte(d, a2); bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_reg(input logic [6:0] off, output logic [7:0] v);
    bit a;
    bus_start(); send_byte(8'hD2, a); send_byte({1'b1, off}, a);
    bus_start(); send_byte(8'hD3, a); recv_byte(1'b1, v); bus_stop();
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++)
      check("R6/R11 reset value", 32'(regs_o[i*8 +: 8]), (i == 7) ? 32'(id_val) : 32'(DEF[i*8 +: 8]));
    check("R10 idle release", 32'(sda_oe), 32'd0);
  endtask

  task automatic t_addr();
    bit a;
    logic [N*8-1:0] snap = regs_o;
    bus_start(); send_byte(8'hA0, a);
    check("R1 foreign address nack", 32'(a), 32'd0);
    send_byte(8'h85, a);
    check("R1 ignored after nack", 32'(a), 32'd0);
    send_byte(8'h55, a); bus_stop();
    check("R1 no write", 32'(regs_o == snap), 32'd1);
    bus_start(); send_byte(8'hD2, a); bus_stop();
    check("R1 own address ack", 32'(a), 32'd1);
  endtask

  task automatic t_byte_write();
    bit ok;
    wr_reg(7'd5, 8'h5A, ok);
    check("R2 acks", 32'(ok), 32'd1);
    check("R2 reg5 stored", 32'(regs_o[5*8 +: 8]), 32'h5A);
    wr_reg(7'd9, 8'h33, ok);
    check("R2 reg9 stored", 32'(regs_o[9*8 +: 8]), 32'h33);
    check("R2 reg8 untouched", 32'(regs_o[8*8 +: 8]), 32'h80);
  endtask

  task automatic t_byte_read();
    logic [7:0] v;
    bit a;
    rd_reg(7'd5, v);
    check("R3 read reg5", 32'(v), 32'h5A);
    rd_reg(7'd0, v);
    check("R3 read reg0", 32'(v), 32'hA1);
    bus_start(); send_byte(8'hD2, a); send_byte(8'h84, a);
    bus_start(); send_byte(8'hD3, a); recv_byte(1'b1, v);
    check("R3 read reg4", 32'(v), 32'hED);
    recv_byte(1'b1, v);
    check("R3 released after nack", 32'(v), 32'hFF);
    bus_stop();
  endtask

  task automatic t_block_write();
    bit a0, a1, a2, a3, a4, a5;
    bus_start(); send_byte(8'hD2, a0); send_byte(8'h00, a1); send_byte(8'h03, a2);
    send_byte(8'h11, a3); send_byte(8'h22, a4); send_byte(8'h33, a5); bus_stop();
    check("R4 all acked", 32'(a0 & a1 & a2 & a3 & a4 & a5), 32'd1);
    check("R4 reg0", 32'(regs_o[0 +: 8]), 32'h11);
    check("R4 reg1", 32'(regs_o[8 +: 8]), 32'h22);
    check("R4 reg2", 32'(regs_o[16 +: 8]), 32'h33);
    check("R4 reg3 untouched", 32'(regs_o[24 +: 8]), 32'hFF);
  endtask

  task automatic t_block_read();
    bit ok, a;
    logic [7:0] v;
    logic [7:0] exp [7] = '{8'h05, 8'h11, 8'h22, 8'h33, 8'hFF, 8'hED, 8'hFF};
    wr_reg(7'd12, 8'h05, ok);
    bus_start(); send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start(); send_byte(8'hD3, a);
    for (int i = 0; i < 7; i++) begin
      recv_byte(i == 6, v);
      check("R5 block read byte", 32'(v), 32'(exp[i]));
    end
    bus_stop();
  endtask

  task automatic t_readonly();
    bit ok;
    logic [7:0] v;
    wr_reg(7'd7, 8'h00, ok);
    check("R7 write acked", 32'(ok), 32'd1);
    check("R7 output keeps id", 32'(regs_o[7*8 +: 8]), 32'h48);
    rd_reg(7'd7, v);
    check("R7 read id", 32'(v), 32'h48);
    id_val = 8'h3C;
    rd_reg(7'd7, v);
    check("R7 read new id", 32'(v), 32'h3C);
  endtask

  task automatic t_range();
    bit ok;
    logic [7:0] v;
    logic [N*8-1:0] snap = regs_o;
    wr_reg(7'd16, 8'h99, ok);
    check("R8 write acked", 32'(ok), 32'd1);
    check("R8 no register changed", 32'(regs_o == snap), 32'd1);
    rd_reg(7'd15, v);
    check("R8 read offset 15", 32'(v), 32'h00);
    rd_reg(7'd127, v);
    check("R8 read offset 127", 32'(v), 32'h00);
  endtask

  task automatic t_abort();
    bit a, ok;
    bus_start(); send_byte(8'hD2, a); send_byte(8'h86, a); send_bits(8'hC3, 4); bus_stop();
    check("R9 stop drops partial byte", 32'(regs_o[6*8 +: 8]), 32'h00);
    check("R10 released after stop", 32'(sda_oe), 32'd0);
    bus_start(); send_byte(8'hD2, a); send_byte(8'h86, a); send_bits(8'hC3, 5);
    bus_start(); send_byte(8'hD2, a); send_byte(8'h86, a); send_byte(8'h77, ok); bus_stop();
    check("R9 restart transaction works", 32'(regs_o[6*8 +: 8]), 32'h77);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr();
    t_byte_write();
    t_byte_read();
    t_block_write();
    t_block_read();
    t_readonly();
    t_range();
    t_abort();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule